// File: doc/BRIEF.md
# Program/Erase Status Polling Engine

This block times an internal byte-program or chip-erase operation in clock cycles and reports its progress through the read data seen by the host. A one-cycle start pulse for a program or an erase loads a down-counter with that operation's duration. The byte written by a program is captured at that point. The busy output stays high until the count runs out, and a one-cycle done pulse follows.

The block sits between the array's read port and the host's data output. A read strobe registers one byte toward the host. While an operation runs, two status bits replace array bits in that byte. Bit 7 carries the inverse of the captured byte's bit 7; an erase captures all ones, so bit 7 reads as 0. Bit 6 alternates on each successive read. Once the operation ends, all eight bits are true array data again.

A start pulse that arrives while the block is busy is dropped. Command decoding, the array itself and the electrical pin timing are handled outside this block.

Top module: `prog_erase_status`

## Requirements
- R1: While reset is high, and on the first cycle after it, `busy`, `done` and `host_rd_data` are all 0.
- R2: A `prog_start` pulse accepted while idle raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYCLES cycles.
- R3: An `erase_start` pulse accepted while idle raises `busy` on the next cycle. `busy` then stays high for exactly ERASE_CYCLES cycles.
- R4: `done` is high for exactly one cycle: the first cycle after the last busy cycle.
- R5: Start pulses of either kind that arrive while `busy` is high are ignored. They change neither the remaining time nor the captured byte.
- R6: When `prog_start` and `erase_start` are high together while idle, the program wins. It takes PROG_CYCLES and captures `load_data`.
- R7: A read strobed while a program is busy returns bit 7 equal to the inverse of bit 7 of the captured `load_data`.
- R8: A read strobed while an erase is busy returns bit 7 equal to 0.
- R9: While busy, bit 6 of read data is 0 on the first read after the start. It then inverts on each further read. Each start resets this sequence.
- R10: While busy, bits 5 to 0 of read data are the array's bits 5 to 0.
- R11: A read strobed while not busy, including the done cycle, returns all eight array bits unchanged.
- R12: `host_rd_data` changes only on a clock edge where `rd_strobe` is high, and shows the new byte from the following cycle. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start | input | 1 | One-cycle request to begin a byte program |
| erase_start | input | 1 | One-cycle request to begin a chip erase |
| load_data | input | 8 | Byte being programmed, captured with `prog_start` |
| rd_strobe | input | 1 | Host read request for this cycle |
| array_rd_data | input | 8 | Read data from the array |
| host_rd_data | output | 8 | Registered read data toward the host |
| busy | output | 1 | High while the timed operation runs |
| done | output | 1 | One-cycle pulse after the operation ends |

## Verification
The bench builds the block with PROG_CYCLES = 9 and ERASE_CYCLES = 23. The default durations correspond to microseconds and seconds, which would take far too many cycles to simulate. With these short values, whole program and erase operations fit in a few dozen cycles, and the two durations stay distinct. That brings several cases within reach: complete polling sequences, reads on every cycle and on sparse cycles, restarts on the done cycle, start pulses landing mid-operation, and a reset during an operation.

// File: rtl/pep_pkg.sv
package pep_pkg;

    localparam int BYTE_W   = 8;
    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;

    typedef enum logic [1:0] {
        OPK_IDLE  = 2'd0,
        OPK_PROG  = 2'd1,
        OPK_ERASE = 2'd2
    } opk_e;

    typedef struct packed {
        opk_e              kind;
        logic [BYTE_W-1:0] loaded;
    } op_ctx_t;

    // Status byte presented while an operation runs.
    function automatic logic [BYTE_W-1:0] poll_byte(
        input op_ctx_t           c,
        input logic              t,
        input logic [BYTE_W-1:0] arr
    );
        logic [BYTE_W-1:0] r;
        r           = arr;
        r[POLL_BIT] = ~c.loaded[POLL_BIT];
        r[TGL_BIT]  = t;
        return r;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pep_launch.sv
module pep_launch
    import pep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              busy,
    output logic              launch,
    output logic              launch_prog,
    output op_ctx_t           ctx
);

    // Starts are accepted only while idle; a program request wins a tie.
    always_comb begin
        launch      = !busy && (prog_start || erase_start);
        launch_prog = prog_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.kind   <= OPK_IDLE;
            ctx.loaded <= '1;
        end else if (launch) begin
            if (launch_prog) begin
                ctx.kind   <= OPK_PROG;
                ctx.loaded <= load_data;
            end else begin
                ctx.kind   <= OPK_ERASE;
                ctx.loaded <= '1;
            end
        end
    end

    AST_CTX_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctx)); // R5

    AST_TIE_PROG: assert property (@(posedge clk) disable iff (rst)
        (!busy && prog_start && erase_start) |=> (ctx.kind == OPK_PROG)); // R6

endmodule

// File: rtl/pep_op_timer.sv
module pep_op_timer #(
    parameter int unsigned PROG_CYCLES  = 12_500,
    parameter int unsigned ERASE_CYCLES = 32'd2_500_000_000,
    parameter int          CNT_W        = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic launch_prog,
    output logic busy,
    output logic done
);

    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] remain_q;
    logic             last_cyc;

    assign last_cyc = busy && (remain_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            remain_q <= '0;
        end else begin
            done <= last_cyc;
            if (launch) begin
                busy     <= 1'b1;
                remain_q <= launch_prog ? PROG_LAST : ERASE_LAST;
            end else if (last_cyc) begin
                busy <= 1'b0;
            end else if (busy) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && remain_q != '0) |=> (busy && remain_q == $past(remain_q) - 1'b1)); // R5

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy || $past(launch)) && $past(busy)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_PROG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (launch && launch_prog) |=> (busy && remain_q == PROG_LAST)); // R2

    AST_ERASE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (launch && !launch_prog) |=> (busy && remain_q == ERASE_LAST)); // R3

endmodule

// File: rtl/pep_toggle_bit.sv
module pep_toggle_bit (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            q <= 1'b0;
        end else if (advance) begin
            q <= ~q;
        end
    end

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear) |=> (q != $past(q))); // R9

    AST_TGL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> !q); // R9

endmodule

// File: rtl/pep_read_path.sv
module pep_read_path
    import pep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_strobe,
    input  logic              busy,
    input  op_ctx_t           ctx,
    input  logic              tgl,
    input  logic [BYTE_W-1:0] array_rd_data,
    output logic [BYTE_W-1:0] host_rd_data
);

    logic [BYTE_W-1:0] next_byte;

    always_comb begin
        next_byte = busy ? poll_byte(ctx, tgl, array_rd_data) : array_rd_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rd_data <= '0;
        end else if (rd_strobe) begin
            host_rd_data <= next_byte;
        end
    end

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(host_rd_data)); // R12

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !busy) |=> (host_rd_data == $past(array_rd_data))); // R11

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && busy && ctx.kind == OPK_PROG)
        |=> (host_rd_data[POLL_BIT] == !$past(ctx.loaded[POLL_BIT]))); // R7

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && busy && ctx.kind == OPK_ERASE) |=> !host_rd_data[POLL_BIT]); // R8

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && busy) |=> (host_rd_data[5:0] == $past(array_rd_data[5:0]))); // R10

endmodule

// File: rtl/prog_erase_status.sv
module prog_erase_status
    import pep_pkg::*;
#(
    parameter int unsigned PROG_CYCLES  = 12_500,
    parameter int unsigned ERASE_CYCLES = 32'd2_500_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              rd_strobe,
    input  logic [BYTE_W-1:0] array_rd_data,
    output logic [BYTE_W-1:0] host_rd_data,
    output logic              busy,
    output logic              done
);

    localparam int unsigned LONGEST = max_u(PROG_CYCLES, ERASE_CYCLES);
    localparam int          CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

    logic    launch;
    logic    launch_prog;
    op_ctx_t ctx;
    logic    tgl;

    initial begin
        if (PROG_CYCLES < 1 || ERASE_CYCLES < 1)
            $error("operation durations must be at least one cycle");
    end

    pep_launch u_launch (
        .clk         (clk),
        .rst         (rst),
        .prog_start  (prog_start),
        .erase_start (erase_start),
        .load_data   (load_data),
        .busy        (busy),
        .launch      (launch),
        .launch_prog (launch_prog),
        .ctx         (ctx)
    );

    pep_op_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES),
        .CNT_W        (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_prog (launch_prog),
        .busy        (busy),
        .done        (done)
    );

    pep_toggle_bit u_toggle (
        .clk     (clk),
        .rst     (rst),
        .clear   (launch),
        .advance (rd_strobe && busy),
        .q       (tgl)
    );

    pep_read_path u_read (
        .clk           (clk),
        .rst           (rst),
        .rd_strobe     (rd_strobe),
        .busy          (busy),
        .ctx           (ctx),
        .tgl           (tgl),
        .array_rd_data (array_rd_data),
        .host_rd_data  (host_rd_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && host_rd_data == '0)); // R1

endmodule

// File: tb/prog_erase_status_tb_top.sv
module prog_erase_status_tb_top;

    localparam int unsigned PC = 9;
    localparam int unsigned EC = 23;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_start = 1'b0;
    logic       erase_start = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_rd_data = 8'h00;
    logic [7:0] host_rd_data;
    logic       busy;
    logic       done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    prog_erase_status #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut_i (
        .clk(clk), .rst(rst), .prog_start(prog_start), .erase_start(erase_start),
        .load_data(load_data), .rd_strobe(rd_strobe), .array_rd_data(array_rd_data),
        .host_rd_data(host_rd_data), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit        m_busy = 0, m_done = 0, m_tgl = 0, m_prog = 0;
    int        m_left = 0;
    bit [7:0]  m_ld = 8'hFF;
    bit [7:0]  m_out = 8'h00;
    string     m_tag = "R1";

    always @(posedge clk) begin
        bit [7:0] b;
        bit       nb, nd, nt, np;
        int       nl;
        bit [7:0] nld;
        if (rst) begin
            m_busy = 0; m_done = 0; m_tgl = 0; m_left = 0; m_out = 0; m_tag = "R1";
        end else begin
            nb = m_busy; nd = 0; nt = m_tgl; nl = m_left; np = m_prog; nld = m_ld;
            if (rd_strobe) begin
                b = array_rd_data;
                if (m_busy) begin
                    b[7] = m_prog ? ~m_ld[7] : 1'b0;
                    b[6] = m_tgl;
                    nt = ~m_tgl;
                    m_tag = m_prog ? "R7 R9 R10" : "R8 R9 R10";
                end else begin
                    m_tag = "R11";
                end
                m_out = b;
            end else begin
                m_tag = "R12";
            end
            if (m_busy) begin
                if (m_left == 1) begin nb = 0; nd = 1; end
                else nl = m_left - 1;
            end else if (prog_start || erase_start) begin
                nb = 1; nt = 0;
                np = prog_start;
                nld = prog_start ? load_data : 8'hFF;
                nl = prog_start ? PC : EC;
            end
            m_busy = nb; m_done = nd; m_tgl = nt; m_left = nl; m_prog = np; m_ld = nld;
        end
    end

    // Busy run-length tracker
    int run = 0, last_len = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(m_prog ? "R2 busy" : "R3 busy", 32'(busy), 32'(m_busy));
            chk("R4 done", 32'(done), 32'(m_done));
            chk(m_tag, 32'(host_rd_data), 32'(m_out));
            if (busy) run++;
            else if (run != 0) begin last_len = run; run = 0; end
        end
    end

    task automatic cyc(input bit ps, input bit es, input bit [7:0] ld,
                       input bit rd, input bit [7:0] arr);
        prog_start = ps; erase_start = es; load_data = ld;
        rd_strobe = rd; array_rd_data = arr;
        @(negedge clk);
    endtask

    // Launch an operation then run n cycles, reading every rd_every cycles.
    task automatic op(input bit ps, input bit es, input bit [7:0] ld,
                      input int n, input int rd_every, input bit [7:0] seed,
                      input bit disturb);
        cyc(ps, es, ld, 1'b0, seed);
        for (int k = 0; k < n; k++) begin
            bit d;
            d = disturb && (k == 2 || k == 5);
            cyc(d && k == 2, d && k == 5, ~ld, (k % rd_every) == 0, 8'(seed + k * 37));
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 0);
        chk("R1 host in reset", 32'(host_rd_data), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 0);
        // idle reads
        cyc(0, 0, 8'h00, 1, 8'hA5);
        cyc(0, 0, 8'h00, 1, 8'h5A);
        cyc(0, 0, 8'h00, 0, 8'h77);
        // program with bit7 set, read every cycle
        op(1, 0, 8'h80, PC + 4, 1, 8'h13, 0);
        chk("R2 program length", 32'(last_len), PC);
        // program with bit7 clear, sparse reads
        op(1, 0, 8'h35, PC + 4, 3, 8'hC4, 0);
        // erase with mid-operation starts that must be ignored
        op(0, 1, 8'h00, EC + 4, 2, 8'h3F, 1);
        chk("R5 erase length after stray starts", 32'(last_len), EC);
        chk("R3 erase length", 32'(last_len), EC);
        // program with stray starts
        op(1, 0, 8'h7E, PC + 3, 1, 8'h81, 1);
        chk("R5 program length after stray starts", 32'(last_len), PC);
        // simultaneous requests: program wins
        op(1, 1, 8'h01, PC + 3, 1, 8'h66, 0);
        chk("R6 tie length", 32'(last_len), PC);
        // restart in the done cycle
        op(1, 0, 8'hF0, PC, 1, 8'h21, 0);
        op(0, 1, 8'h00, EC + 3, 1, 8'h9C, 0);
        chk("R4 back-to-back erase length", 32'(last_len), EC);
        // reset mid-erase
        op(0, 1, 8'h00, 5, 1, 8'h44, 0);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        run = 0;
        chk("R1 busy after mid reset", 32'(busy), 0);
        chk("R1 host after mid reset", 32'(host_rd_data), 0);
        rst = 0;
        @(negedge clk);
        op(1, 0, 8'hAA, PC + 3, 1, 8'h0F, 0);
        chk("R2 program after reset", 32'(last_len), PC);
        finished = 1;
        summary();
        $finish;
    end

endmodule